// File: doc/BRIEF.md
# Per-Line Video Byte Stream Formatter

This block turns decoded 4:2:2 video into the single 8-bit byte stream of a digital video port. Two sample streams feed it. The processed stream delivers one item per pixel: a chroma byte, with Cb and Cr alternating as the producer supplies them, and a luma byte. The composite stream delivers one raw composite sample per pixel. Each line of active data goes out as 2·PIX bytes in chroma, luma, chroma, luma order. A start reference comes directly before those bytes and an end reference directly after them. Each reference is four bytes: FF, 00, 00, then a code byte. Between lines the port sends the blanking pair 80h, 10h.

A table with one 4-bit type per line, for lines 2 to 24, sets the content of the luma slots for each line. Processed luma is used for type 15 (active video) and type 6 (test line). Raw composite samples are used for every other type. The reference codes can be suppressed so that blanking runs straight through them. A test override takes priority over everything else. It sends 8 bits of the ADC samples straight to the port and emits no reference codes.

The configuration and the line-type table arrive as static inputs. A line begins on a falling edge of the horizontal blanking input.

Top module: `vfmt_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dout_o` is 10h and `vid_ready_o`, `raw_ready_o` and `underrun_o` are 0. After reset the blanking sequence starts with 80h.
- R2: `dout_o` shows the byte chosen in a cycle one clock later. A line is the four reference bytes FF, 00, 00, code (H=0), then exactly 2·PIX data bytes, then FF, 00, 00, code (H=1). No other byte comes between these parts.
- R3: The code byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, bit 7 first.
- R4: F and V are sampled from `field_i` and `vblank_i` in the cycle of the last data byte. They are held unchanged for that line's end reference and the next line's start reference.
- R5: Outside lines the port alternates 80h and 10h, starting with 80h after each end reference. A falling edge of `hblank_i` arms a line start. The start reference begins in the first following cycle whose blanking byte would be 80h.
- R6: Data bytes alternate between a chroma slot (processed chroma) and a luma slot. On lines of type 15 or 6 the luma slot carries processed luma.
- R7: A line's type is latched when its start reference begins. For line numbers 2 to 24 the type is `type_tbl_i[4*(n-2) +: 4]`, and every other line number uses type 15. On lines of any type other than 15 or 6, the luma slots carry the composite samples.
- R8: With `sup_codes_i` = 1, each reference's four bytes become 80h, 10h, 80h, 10h.
- R9: With `tst_en_i` = 1, the port carries `adc_a_i` on every cycle when `tst_dual_i` = 0. When `tst_dual_i` = 1 it alternates `adc_a_i` and `adc_b_i`, starting with A. The byte is bits [ADC_W-1:ADC_W-8] when `tst_hi_i` = 1 and bits [7:0] otherwise. No reference codes are sent, both ready outputs stay 0, and any line in progress is abandoned. After the override ends, blanking resumes with 80h.
- R10: `vid_ready_o` is 1 exactly in luma slots. `raw_ready_o` is 1 exactly in luma slots of lines that use composite samples. An item is consumed when its valid and ready are both 1.
- R11: A slot whose samples are missing outputs 80h for a chroma slot or 10h for a luma slot, and it sets `underrun_o`. A chroma slot needs processed data. A luma slot needs processed data, and on composite lines also composite data. `underrun_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hblank_i | input | 1 | Horizontal blanking; a falling edge arms a line |
| field_i | input | 1 | Field flag for the codes |
| vblank_i | input | 1 | Vertical blanking flag for the codes |
| line_i | input | LINE_W | Current line number |
| type_tbl_i | input | 4·NLT | Per-line type table, entry for line 2 in the low nibble |
| sup_codes_i | input | 1 | Replace reference codes with blanking |
| tst_en_i | input | 1 | ADC bypass test override |
| tst_hi_i | input | 1 | Select upper ADC bits in test override |
| tst_dual_i | input | 1 | Alternate two ADCs in test override |
| adc_a_i | input | ADC_W | First ADC sample |
| adc_b_i | input | ADC_W | Second ADC sample |
| vid_valid_i | input | 1 | Processed item available |
| vid_ready_o | output | 1 | Processed item consumed this cycle if valid |
| vid_c_i | input | 8 | Processed chroma byte |
| vid_y_i | input | 8 | Processed luma byte |
| raw_valid_i | input | 1 | Composite sample available |
| raw_ready_o | output | 1 | Composite sample consumed this cycle if valid |
| raw_i | input | 8 | Composite sample |
| dout_o | output | 8 | Port byte |
| underrun_o | output | 1 | Sticky missing-sample flag |

## Verification
The assertions rely on three things. The line-type table and `sup_codes_i` are held stable across a line. `hblank_i` gives at most one falling edge per line. Each line period is long enough for the line to finish before the next edge. The stimulus drives every line period with 13 or 14 cycles of blanking high and 47 cycles low, and changes the table only before the lines begin. Field and vertical-blanking flags are changed at line starts, well away from the sampling cycle. Test mode is entered and left at arbitrary points, and no assertion depends on reference continuity across that transition.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    localparam logic [7:0] BLK_C = 8'h80;
    localparam logic [7:0] BLK_Y = 8'h10;
    localparam logic [3:0] TYPE_ACTIVE = 4'd15;
    localparam logic [3:0] TYPE_TESTLINE = 4'd6;

    typedef enum logic [1:0] {ST_BLANK, ST_SAV, ST_ACT, ST_EAV} seq_st_e;

    typedef enum logic [2:0] {SL_BLK80, SL_BLK10, SL_REF, SL_CHR, SL_LUM, SL_TST} slot_e;

    typedef struct packed {
        slot_e      kind;
        logic [1:0] idx;
        logic       h;
        logic       f;
        logic       v;
        logic       raw;
    } slot_t;

    function automatic logic [7:0] ref_code(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic type_is_raw(input logic [3:0] t);
        return !(t == TYPE_ACTIVE || t == TYPE_TESTLINE);
    endfunction

endpackage

// File: rtl/vfmt_line_type.sv
module vfmt_line_type
    import vfmt_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int FIRST  = 2,
    parameter int NLT    = 23
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [4*NLT-1:0]  tbl_i,
    output logic              raw_o
);
    logic [3:0] ltype;

    always_comb begin
        ltype = TYPE_ACTIVE;
        for (int i = 0; i < NLT; i++) begin
            if (line_i == LINE_W'(FIRST + i)) ltype = tbl_i[4*i +: 4];
        end
        raw_o = type_is_raw(ltype);
    end
endmodule

// File: rtl/vfmt_seq.sv
module vfmt_seq
    import vfmt_pkg::*;
#(
    parameter int PIX = 720
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  test_i,
    input  logic  hblank_i,
    input  logic  field_i,
    input  logic  vblank_i,
    input  logic  raw_line_i,
    output slot_t slot_o
);
    localparam int LINE_BYTES = 2 * PIX;
    localparam int CNT_W = $clog2(LINE_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_BYTES - 1);
    localparam logic [CNT_W-1:0] REF_END = CNT_W'(3);

    seq_st_e          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ph_q, hb_q, pend_q, f_q, v_q, raw_q;
    logic             fall, go;

    assign fall = hb_q & ~hblank_i;
    assign go   = pend_q & ~ph_q;

    always_comb begin
        slot_o.idx = cnt_q[1:0];
        slot_o.h   = 1'b0;
        slot_o.f   = f_q;
        slot_o.v   = v_q;
        slot_o.raw = raw_q;
        if (test_i) begin
            slot_o.kind = SL_TST;
        end else begin
            unique case (st_q)
                ST_BLANK: begin
                    slot_o.kind = go ? SL_REF : (ph_q ? SL_BLK10 : SL_BLK80);
                    slot_o.idx  = 2'd0;
                end
                ST_SAV:  slot_o.kind = SL_REF;
                ST_ACT:  slot_o.kind = cnt_q[0] ? SL_LUM : SL_CHR;
                default: begin
                    slot_o.kind = SL_REF;
                    slot_o.h    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_BLANK;
            cnt_q  <= '0;
            ph_q   <= 1'b0;
            hb_q   <= 1'b1;
            pend_q <= 1'b0;
            f_q    <= 1'b0;
            v_q    <= 1'b0;
            raw_q  <= 1'b0;
        end else begin
            hb_q <= hblank_i;
            if (test_i) begin
                st_q   <= ST_BLANK;
                cnt_q  <= '0;
                ph_q   <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_BLANK: begin
                        if (go) begin
                            st_q   <= ST_SAV;
                            cnt_q  <= CNT_W'(1);
                            pend_q <= fall;
                            raw_q  <= raw_line_i;
                        end else begin
                            ph_q   <= ~ph_q;
                            pend_q <= pend_q | fall;
                        end
                    end
                    ST_SAV: begin
                        pend_q <= pend_q | fall;
                        if (cnt_q == REF_END) begin
                            st_q  <= ST_ACT;
                            cnt_q <= '0;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    ST_ACT: begin
                        pend_q <= pend_q | fall;
                        if (cnt_q == LAST) begin
                            st_q  <= ST_EAV;
                            cnt_q <= '0;
                            f_q   <= field_i;
                            v_q   <= vblank_i;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    default: begin
                        pend_q <= pend_q | fall;
                        if (cnt_q == REF_END) begin
                            st_q  <= ST_BLANK;
                            cnt_q <= '0;
                            ph_q  <= 1'b0;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                endcase
            end
        end
    end

    // R2: reference bytes follow each other in order unless the override cuts in
    p_ref_order_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_o.kind == SL_REF && slot_o.idx != 2'd3)
        |=> (test_i || (slot_o.kind == SL_REF && slot_o.idx == $past(slot_o.idx) + 2'd1)));

    // R4: flags change only when the last data byte hands over to the end reference
    p_fv_at_eav_r4: assert property (@(posedge clk) disable iff (rst)
        !(st_q == ST_ACT && cnt_q == LAST && !test_i) |=> ($stable(f_q) && $stable(v_q)));
endmodule

// File: rtl/vfmt_byte_sel.sv
module vfmt_byte_sel
    import vfmt_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  slot_t            slot_i,
    input  logic             sup_i,
    input  logic             vid_valid_i,
    input  logic [7:0]       vid_c_i,
    input  logic [7:0]       vid_y_i,
    input  logic             raw_valid_i,
    input  logic [7:0]       raw_i,
    input  logic [ADC_W-1:0] adc_a_i,
    input  logic [ADC_W-1:0] adc_b_i,
    input  logic             tst_hi_i,
    input  logic             tsel_i,
    output logic [7:0]       byte_o,
    output logic             miss_o
);
    logic [ADC_W-1:0] adc;
    logic             luma_ok;

    assign adc     = tsel_i ? adc_b_i : adc_a_i;
    assign luma_ok = vid_valid_i && (!slot_i.raw || raw_valid_i);

    always_comb begin
        miss_o = 1'b0;
        unique case (slot_i.kind)
            SL_BLK80: byte_o = BLK_C;
            SL_BLK10: byte_o = BLK_Y;
            SL_REF: begin
                if (sup_i)                   byte_o = slot_i.idx[0] ? BLK_Y : BLK_C;
                else if (slot_i.idx == 2'd0) byte_o = 8'hFF;
                else if (slot_i.idx == 2'd3) byte_o = ref_code(slot_i.f, slot_i.v, slot_i.h);
                else                         byte_o = 8'h00;
            end
            SL_CHR: begin
                byte_o = vid_valid_i ? vid_c_i : BLK_C;
                miss_o = !vid_valid_i;
            end
            SL_LUM: begin
                byte_o = !luma_ok ? BLK_Y : (slot_i.raw ? raw_i : vid_y_i);
                miss_o = !luma_ok;
            end
            default: byte_o = tst_hi_i ? adc[ADC_W-1 -: 8] : adc[7:0];
        endcase
    end
endmodule

// File: rtl/vfmt_top.sv
module vfmt_top
    import vfmt_pkg::*;
#(
    parameter int PIX    = 720,
    parameter int LINE_W = 10,
    parameter int NLT    = 23,
    parameter int ADC_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hblank_i,
    input  logic              field_i,
    input  logic              vblank_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [4*NLT-1:0]  type_tbl_i,
    input  logic              sup_codes_i,
    input  logic              tst_en_i,
    input  logic              tst_hi_i,
    input  logic              tst_dual_i,
    input  logic [ADC_W-1:0]  adc_a_i,
    input  logic [ADC_W-1:0]  adc_b_i,
    input  logic              vid_valid_i,
    output logic              vid_ready_o,
    input  logic [7:0]        vid_c_i,
    input  logic [7:0]        vid_y_i,
    input  logic              raw_valid_i,
    output logic              raw_ready_o,
    input  logic [7:0]        raw_i,
    output logic [7:0]        dout_o,
    output logic              underrun_o
);
    slot_t      slot;
    logic       raw_line, miss, tsel_q;
    logic [7:0] byte_d;

    vfmt_line_type #(.LINE_W(LINE_W), .FIRST(2), .NLT(NLT)) u_ltype (
        .line_i(line_i), .tbl_i(type_tbl_i), .raw_o(raw_line));

    vfmt_seq #(.PIX(PIX)) u_seq (
        .clk(clk), .rst(rst), .test_i(tst_en_i), .hblank_i(hblank_i),
        .field_i(field_i), .vblank_i(vblank_i), .raw_line_i(raw_line), .slot_o(slot));

    vfmt_byte_sel #(.ADC_W(ADC_W)) u_sel (
        .slot_i(slot), .sup_i(sup_codes_i), .vid_valid_i(vid_valid_i),
        .vid_c_i(vid_c_i), .vid_y_i(vid_y_i), .raw_valid_i(raw_valid_i), .raw_i(raw_i),
        .adc_a_i(adc_a_i), .adc_b_i(adc_b_i), .tst_hi_i(tst_hi_i), .tsel_i(tsel_q),
        .byte_o(byte_d), .miss_o(miss));

    assign vid_ready_o = (slot.kind == SL_LUM);
    assign raw_ready_o = (slot.kind == SL_LUM) && slot.raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o     <= BLK_Y;
            underrun_o <= 1'b0;
            tsel_q     <= 1'b0;
        end else begin
            dout_o     <= byte_d;
            underrun_o <= underrun_o | miss;
            tsel_q     <= tst_en_i && tst_dual_i && !tsel_q;
        end
    end

    // R11: the missing-sample flag never clears outside reset
    p_under_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> underrun_o);

    // R9: no sample is consumed during the test override
    p_test_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        tst_en_i |-> (!vid_ready_o && !raw_ready_o));

    // R10: composite samples are only taken together with a processed item slot
    p_raw_with_vid_r10: assert property (@(posedge clk) disable iff (rst)
        raw_ready_o |-> vid_ready_o);

    // R3: an unsuppressed code byte carries the marker bit and the slot's flags
    p_code_flags_r3: assert property (@(posedge clk) disable iff (rst)
        (slot.kind == SL_REF && slot.idx == 2'd3 && !sup_codes_i)
        |=> (dout_o[7] && dout_o[6] == $past(slot.f) && dout_o[5] == $past(slot.v)
             && dout_o[4] == $past(slot.h)));
endmodule

// File: tb/vfmt_top_tb.sv
module vfmt_top_tb;
    localparam int PIX = 16;
    localparam int LINE_W = 10;
    localparam int NLT = 23;
    localparam int ADC_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hblank_i = 1'b1, field_i = 1'b0, vblank_i = 1'b0;
    logic [LINE_W-1:0] line_i = '0;
    logic [4*NLT-1:0] type_tbl_i = '0;
    logic sup_codes_i = 1'b0, tst_en_i = 1'b0, tst_hi_i = 1'b0, tst_dual_i = 1'b0;
    logic [ADC_W-1:0] adc_a_i = '0, adc_b_i = '0;
    logic vid_valid_i = 1'b1, raw_valid_i = 1'b1;
    logic [7:0] vid_c_i = '0, vid_y_i = '0, raw_i = '0;
    logic vid_ready_o, raw_ready_o, underrun_o;
    logic [7:0] dout_o;

    int n_checks = 0, n_fail = 0;

    always #5 clk = ~clk;

    vfmt_top #(.PIX(PIX), .LINE_W(LINE_W), .NLT(NLT), .ADC_W(ADC_W)) u_dut (.*);

    // reference model state
    int m_st, m_cnt, m_k, m_r;
    bit m_ph, m_hbq, m_pend, m_f, m_v, m_raw, m_under, m_tsel;
    logic [7:0] m_dout;
    string m_tag;
    int types [NLT];

    function automatic bit line_raw(int ln);
        int t = 15;
        if (ln >= 2 && ln <= 24) t = types[ln-2];
        return !(t == 15 || t == 6);
    endfunction

    function automatic logic [7:0] cval(int k); return 8'((k * 3 + 1) & 255); endfunction
    function automatic logic [7:0] yval(int k); return 8'((k * 5 + 40) & 255); endfunction
    function automatic logic [7:0] rval(int r); return 8'((r * 7 + 200) & 255); endfunction

    function automatic logic [7:0] ref_byte(int idx, bit h, bit f, bit v, bit s);
        if (s) return (idx % 2 == 1) ? 8'h10 : 8'h80;
        if (idx == 0) return 8'hFF;
        if (idx < 3) return 8'h00;
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    always @(posedge clk) begin
        bit fall;
        if (rst) begin
            m_dout = 8'h10; m_st = 0; m_cnt = 0; m_ph = 0; m_hbq = 1; m_pend = 0;
            m_f = 0; m_v = 0; m_raw = 0; m_under = 0; m_tsel = 0; m_k = 0; m_r = 0;
            m_tag = "R1";
        end else begin
            fall = m_hbq && !hblank_i;
            m_hbq = hblank_i;
            if (tst_en_i) begin
                logic [ADC_W-1:0] a;
                a = (tst_dual_i && m_tsel) ? adc_b_i : adc_a_i;
                m_dout = tst_hi_i ? a[9:2] : a[7:0];
                m_tsel = tst_dual_i ? !m_tsel : 1'b0;
                m_st = 0; m_cnt = 0; m_ph = 0; m_pend = 0;
                m_tag = "R9";
            end else begin
                m_tsel = 0;
                case (m_st)
                    0: if (m_pend && !m_ph) begin
                            m_dout = ref_byte(0, 0, m_f, m_v, sup_codes_i);
                            m_st = 1; m_cnt = 1; m_pend = fall; m_raw = line_raw(int'(line_i));
                            m_tag = sup_codes_i ? "R8" : "R5";
                        end else begin
                            m_dout = m_ph ? 8'h10 : 8'h80;
                            m_ph = !m_ph; m_pend = m_pend | fall;
                            m_tag = "R5";
                        end
                    1, 3: begin
                            m_dout = ref_byte(m_cnt, m_st == 3, m_f, m_v, sup_codes_i);
                            m_tag = sup_codes_i ? "R8" : (m_cnt == 3 ? (m_st == 3 ? "R4" : "R3") : "R2");
                            m_pend = m_pend | fall;
                            if (m_cnt == 3) begin
                                if (m_st == 3) m_ph = 0;
                                m_st = (m_st == 1) ? 2 : 0; m_cnt = 0;
                            end else m_cnt++;
                        end
                    default: begin
                            m_pend = m_pend | fall;
                            if (m_cnt % 2 == 0) begin
                                m_tag = "R6";
                                if (vid_valid_i) m_dout = cval(m_k);
                                else begin m_dout = 8'h80; m_under = 1; m_tag = "R11"; end
                            end else begin
                                m_tag = m_raw ? "R7" : "R6";
                                if (vid_valid_i && (!m_raw || raw_valid_i))
                                    m_dout = m_raw ? rval(m_r) : yval(m_k);
                                else begin m_dout = 8'h10; m_under = 1; m_tag = "R11"; end
                                if (vid_valid_i) m_k++;
                                if (m_raw && raw_valid_i) m_r++;
                            end
                            if (m_cnt == 2 * PIX - 1) begin
                                m_st = 3; m_cnt = 0; m_f = field_i; m_v = vblank_i;
                            end else m_cnt++;
                        end
                endcase
            end
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        bit er;
        @(negedge clk);
        er = !tst_en_i && m_st == 2 && (m_cnt % 2 == 1);
        check(m_tag, dout_o, m_dout, "dout");
        check("R10", vid_ready_o, er, "vid_ready");
        check("R10", raw_ready_o, er && m_raw, "raw_ready");
        check("R11", underrun_o, m_under, "underrun");
        vid_c_i = cval(m_k); vid_y_i = yval(m_k); raw_i = rval(m_r);
    endtask

    task automatic run_line(int ln, bit f, bit v, bit s, int hb_hi, int drop_v, int drop_r);
        line_i = LINE_W'(ln); field_i = f; vblank_i = v; sup_codes_i = s;
        hblank_i = 1'b1;
        for (int i = 0; i < hb_hi; i++) step();
        hblank_i = 1'b0;
        for (int i = 0; i < 47; i++) begin
            vid_valid_i = (i != drop_v);
            raw_valid_i = (i != drop_r);
            step();
        end
        vid_valid_i = 1'b1; raw_valid_i = 1'b1;
    endtask

    task automatic run_test(bit hi, bit dual, int n);
        tst_en_i = 1'b1; tst_hi_i = hi; tst_dual_i = dual;
        for (int i = 0; i < n; i++) begin
            adc_a_i = ADC_W'(i * 37 + 5);
            adc_b_i = ADC_W'(i * 91 + 700);
            step();
        end
        tst_en_i = 1'b0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NLT; i++) types[i] = 15;
        types[0] = 14; types[3] = 3; types[4] = 6; types[5] = 15; types[22] = 0; types[10] = 7;
        for (int i = 0; i < NLT; i++) type_tbl_i[4*i +: 4] = 4'(types[i]);
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", dout_o, 8'h10, "reset dout");
            check("R1", vid_ready_o, 0, "reset vid_ready");
            check("R1", underrun_o, 0, "reset underrun");
        end
        rst = 1'b0;
        step();
        run_line(1, 0, 1, 0, 13, -1, -1);
        run_line(2, 1, 1, 0, 14, -1, -1);   // R7 raw type 14
        run_line(5, 0, 0, 0, 13, -1, -1);   // R7 raw type 3
        run_line(6, 1, 0, 0, 14, -1, -1);   // R6 test line type
        run_line(7, 0, 0, 0, 13, -1, -1);
        run_line(24, 1, 1, 0, 13, -1, -1);  // R7 last table entry
        run_line(25, 0, 0, 0, 14, -1, -1);  // R6 beyond table
        run_line(12, 1, 0, 0, 13, -1, -1);  // R7 type 7
        run_line(100, 0, 1, 1, 13, -1, -1); // R8 suppressed codes
        run_line(5, 1, 1, 1, 14, -1, -1);   // R8 on a raw line
        run_line(7, 0, 0, 0, 13, 20, -1);   // R11 processed miss
        run_line(5, 1, 0, 0, 14, -1, 25);   // R11 composite miss
        run_test(1, 1, 21);                 // R9 dual upper
        run_line(7, 0, 1, 0, 13, -1, -1);
        hblank_i = 1'b1;
        for (int i = 0; i < 20; i++) step();
        hblank_i = 1'b0;
        for (int i = 0; i < 10; i++) step();
        run_test(0, 0, 15);                 // R9 single lower, cuts a line
        run_test(1, 0, 6);
        run_line(2, 1, 1, 0, 13, -1, -1);
        run_line(300, 0, 0, 0, 14, -1, -1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule